// File: doc/BRIEF.md
# Prescaled Core Watchdog Timer

This block is a per-core watchdog with a 64-bit register interface. It has two registers. The setup register holds the operating level, a 16-bit reload value and a 24-bit live count. The restart register reloads the count whenever software writes it. A fixed prescaler divides the input clock by 1024, and the count drops by one on each prescaler tick. The reload value fills only the upper 16 bits of the 24-bit count, so a reload loads the counter with the reload value shifted left by eight.

A tick that finds the count at zero is an expiry. On an expiry the count is reloaded and the block escalates according to the operating level. The first expiry raises an interrupt pulse. A later expiry raises a non-maskable interrupt pulse. At the highest level the third expiry raises a system reset request. This request stays high until the block itself is reset.

Writing the restart register, or rewriting the setup register, clears the escalation stage and the prescaler. Level 0 stops the counter completely.

Top module: `core_watchdog`

## Requirements
- R1: After reset, irq_o, nmi_o and rst_req_o are 0, and a read of the setup register returns 0.
- R2: While the level is nonzero, the count drops by one every 1024 clocks. After a write to either register, the first drop comes 1024 clock edges after the write edge.
- R3: A write with wr_en at offset 0x40000 loads three fields at the next edge: level from wdata[1:0], reload value from wdata[19:4] and count from wdata[43:20]. All other wdata bits are ignored.
- R4: A write at offset 0x50000, with any data, sets the count to the reload value shifted left by 8 (reload x 256) and clears the escalation stage. This holds at any level.
- R5: At level 0 the count holds its value and no expiry output is raised.
- R6: An expiry is a prescaler tick while the count is 0. It reloads the count to reload x 256. At levels 1 to 3, the first expiry after a register write gives a one-cycle irq_o pulse. At level 1, every expiry gives one.
- R7: At level 2, the second and every later expiry gives a one-cycle nmi_o pulse instead of irq_o. At level 3, the second expiry gives one nmi_o pulse.
- R8: At level 3, the third expiry sets rst_req_o. It stays 1, with no further irq_o or nmi_o pulses, until rst_n is asserted.
- R9: When rd_en is high and addr is 0x40000, rdata carries the level in [1:0], the reload value in [19:4] and the live count in [43:20], with all other bits 0. In every other case rdata is 0.
- R10: Writes to any offset other than 0x40000 and 0x50000 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe, data returned in the same cycle |
| addr | input | 20 | Byte offset within the block window |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data |
| irq_o | output | 1 | First-stage expiry pulse |
| nmi_o | output | 1 | Second-stage expiry pulse |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
The assertions assume that wr_en and rd_en are single-cycle strobes, driven with known values and a stable address at each clock edge. They also assume that expiries are at least one prescaler period apart, which the fixed divider guarantees. The stimulus changes inputs only on falling edges and writes one register per strobe. Short counts and a zero reload value keep each escalation sequence to a few thousand cycles, so every stage is reached.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int WORD_W   = 64;
  localparam int LVL_W    = 2;
  localparam int RLD_W    = 16;
  localparam int CNT_W    = 24;
  localparam int RLD_SH   = CNT_W - RLD_W;
  localparam int LVL_LSB  = 0;
  localparam int RLD_LSB  = 4;
  localparam int CNT_LSB  = 20;
  localparam int STAGE_W  = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_OFF  = 2'd0,
    LVL_INT  = 2'd1,
    LVL_NMI  = 2'd2,
    LVL_RST  = 2'd3
  } wd_level_e;
endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int SETUP_AD = 'h40000,
  parameter int KICK_AD  = 'h50000
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  wd_level_e         lvl,
  input  logic [RLD_W-1:0]  rld,
  input  logic [CNT_W-1:0]  cnt,
  output logic              setup_wr,
  output logic              kick_wr,
  output wd_level_e         new_lvl,
  output logic [RLD_W-1:0]  new_rld,
  output logic [CNT_W-1:0]  new_cnt,
  output logic [WORD_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] SETUP_A = ADDR_W'(SETUP_AD);
  localparam logic [ADDR_W-1:0] KICK_A  = ADDR_W'(KICK_AD);

  logic hit_setup;
  assign hit_setup = (addr == SETUP_A);
  assign setup_wr  = wr_en && hit_setup;
  assign kick_wr   = wr_en && (addr == KICK_A);

  assign new_lvl = wd_level_e'(wdata[LVL_LSB +: LVL_W]);
  assign new_rld = wdata[RLD_LSB +: RLD_W];
  assign new_cnt = wdata[CNT_LSB +: CNT_W];

  always_comb begin
    rdata = '0;
    if (rd_en && hit_setup) begin
      rdata[LVL_LSB +: LVL_W] = lvl;
      rdata[RLD_LSB +: RLD_W] = rld;
      rdata[CNT_LSB +: CNT_W] = cnt;
    end
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV_LOG2 = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  logic [DIV_LOG2-1:0] pre_q, pre_d;

  assign tick = run && !clear && (&pre_q);

  always_comb begin
    if (clear || !run) pre_d = '0;
    else               pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               setup_wr,
  input  logic               kick_wr,
  input  wd_level_e          new_lvl,
  input  logic [RLD_W-1:0]   new_rld,
  input  logic [CNT_W-1:0]   new_cnt,
  input  logic               tick,
  output wd_level_e          lvl_q,
  output logic [RLD_W-1:0]   rld_q,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               expire,
  output logic [STAGE_W-1:0] exp_stage
);
  wd_level_e          lvl_d;
  logic [RLD_W-1:0]   rld_d;
  logic [CNT_W-1:0]   cnt_d, reload;
  logic [STAGE_W-1:0] stage_q, stage_d;
  logic               lvl_en, cnt_en, stage_en;

  assign reload    = {rld_q, {RLD_SH{1'b0}}};
  assign expire    = tick && (cnt_q == '0);
  assign exp_stage = (&stage_q) ? stage_q : stage_q + 1'b1;

  always_comb begin
    lvl_d    = lvl_q;
    rld_d    = rld_q;
    cnt_d    = cnt_q;
    stage_d  = stage_q;
    lvl_en   = 1'b0;
    cnt_en   = 1'b0;
    stage_en = 1'b0;
    if (setup_wr) begin
      lvl_d    = new_lvl;
      rld_d    = new_rld;
      cnt_d    = new_cnt;
      stage_d  = '0;
      lvl_en   = 1'b1;
      cnt_en   = 1'b1;
      stage_en = 1'b1;
    end else if (kick_wr) begin
      cnt_d    = reload;
      stage_d  = '0;
      cnt_en   = 1'b1;
      stage_en = 1'b1;
    end else if (tick) begin
      cnt_en = 1'b1;
      if (expire) begin
        cnt_d    = reload;
        stage_d  = exp_stage;
        stage_en = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_OFF;
      rld_q <= '0;
    end else if (lvl_en) begin
      lvl_q <= lvl_d;
      rld_q <= rld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_en) stage_q <= stage_d;
  end
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate
  import wdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               expire,
  input  wd_level_e          lvl,
  input  logic [STAGE_W-1:0] exp_stage,
  output logic               irq_q,
  output logic               nmi_q,
  output logic               rst_q
);
  logic irq_d, nmi_d, rst_d;
  logic last_stage;

  assign last_stage = (lvl == LVL_RST) && (exp_stage == STAGE_W'(3));

  always_comb begin
    irq_d = expire && ((exp_stage == STAGE_W'(1)) || (lvl == LVL_INT));
    nmi_d = expire && (lvl != LVL_INT) && (exp_stage >= STAGE_W'(2)) && !last_stage;
    rst_d = rst_q || (expire && last_stage);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      nmi_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      nmi_q <= nmi_d;
      rst_q <= rst_d;
    end
  end
endmodule

// File: rtl/core_watchdog.sv
module core_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int SETUP_AD = 'h40000,
  parameter int KICK_AD  = 'h50000,
  parameter int DIV_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata,
  output logic              irq_o,
  output logic              nmi_o,
  output logic              rst_req_o
);
  logic [1:0] sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_int_n = sync_q[1];

  logic               setup_wr, kick_wr, tick, expire;
  wd_level_e          new_lvl, lvl_q;
  logic [RLD_W-1:0]   new_rld, rld_q;
  logic [CNT_W-1:0]   new_cnt, cnt_q;
  logic [STAGE_W-1:0] exp_stage;

  wdt_regif #(.ADDR_W(ADDR_W), .SETUP_AD(SETUP_AD), .KICK_AD(KICK_AD)) u_regif (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .lvl(lvl_q), .rld(rld_q), .cnt(cnt_q),
    .setup_wr(setup_wr), .kick_wr(kick_wr),
    .new_lvl(new_lvl), .new_rld(new_rld), .new_cnt(new_cnt), .rdata(rdata)
  );

  wdt_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .run(lvl_q != LVL_OFF),
    .clear(setup_wr || kick_wr), .tick(tick)
  );

  wdt_counter u_cnt (
    .clk(clk), .rst_n(rst_int_n), .setup_wr(setup_wr), .kick_wr(kick_wr),
    .new_lvl(new_lvl), .new_rld(new_rld), .new_cnt(new_cnt), .tick(tick),
    .lvl_q(lvl_q), .rld_q(rld_q), .cnt_q(cnt_q),
    .expire(expire), .exp_stage(exp_stage)
  );

  wdt_escalate u_esc (
    .clk(clk), .rst_n(rst_int_n), .expire(expire), .lvl(lvl_q),
    .exp_stage(exp_stage), .irq_q(irq_o), .nmi_q(nmi_o), .rst_q(rst_req_o)
  );
endmodule

// File: rtl/core_watchdog_chk.sv
module core_watchdog_chk
  import wdt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             setup_wr,
  input logic             kick_wr,
  input logic [63:0]      wdata,
  input logic             tick,
  input logic [1:0]       lvl,
  input logic [RLD_W-1:0] rld,
  input logic [CNT_W-1:0] cnt,
  input logic             irq,
  input logic             nmi,
  input logic             rstq
);
  AST_SETUP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    setup_wr |=> (lvl == $past(wdata[1:0]) && cnt == $past(wdata[43:20]) && rld == $past(wdata[19:4]))); // R3
  AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    kick_wr |=> (cnt == {$past(rld), 8'h00})); // R4
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !tick) |=> $stable(cnt)); // R2
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
  AST_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == 2'd0 && !wr_en) |=> (!irq && !nmi && $stable(cnt))); // R5
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R6
  AST_NMI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> !nmi); // R7
  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq, nmi, $rose(rstq)})); // R7
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rstq |=> rstq); // R8
endmodule

bind core_watchdog core_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .setup_wr(setup_wr), .kick_wr(kick_wr),
  .wdata(wdata), .tick(tick), .lvl(lvl_q), .rld(rld_q), .cnt(cnt_q),
  .irq(irq_o), .nmi(nmi_o), .rstq(rst_req_o)
);

// File: tb/tb_core_watchdog.sv
`timescale 1ns/1ps
module tb_core_watchdog;
  localparam logic [19:0] A_SETUP = 20'h40000;
  localparam logic [19:0] A_KICK  = 20'h50000;

  logic        clk, rst_n, wr_en, rd_en;
  logic [19:0] addr;
  logic [63:0] wdata, rdata;
  logic        irq_o, nmi_o, rst_req_o;

  core_watchdog dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int n_irq = 0, n_nmi = 0;
  bit done = 0;

  // behavioural reference model
  int m_lvl, m_rld, m_cnt, m_pre, m_stage;
  bit m_irq, m_nmi, m_rst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 0; m_rld = 0; m_cnt = 0; m_pre = 0; m_stage = 0;
      m_irq = 0; m_nmi = 0; m_rst = 0;
    end else begin
      m_irq = 0; m_nmi = 0;
      if (wr_en && addr == A_SETUP) begin
        m_lvl = wdata[1:0]; m_rld = wdata[19:4]; m_cnt = wdata[43:20];
        m_pre = 0; m_stage = 0;
      end else if (wr_en && addr == A_KICK) begin
        m_cnt = m_rld * 256; m_pre = 0; m_stage = 0;
      end else if (m_lvl != 0) begin
        if (m_pre == 1023) begin
          m_pre = 0;
          if (m_cnt == 0) begin
            if (m_stage < 3) m_stage++;
            m_cnt = m_rld * 256;
            if (m_lvl == 1) m_irq = 1;
            else if (m_stage == 1) m_irq = 1;
            else if (m_lvl == 2) m_nmi = 1;
            else if (m_stage == 2) m_nmi = 1;
            else m_rst = 1;
          end else m_cnt--;
        end else m_pre++;
      end else m_pre = 0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      logic [63:0] exp_rd;
      exp_rd = '0;
      if (rd_en && addr == A_SETUP) begin
        exp_rd[1:0]   = m_lvl[1:0];
        exp_rd[19:4]  = m_rld[15:0];
        exp_rd[43:20] = m_cnt[23:0];
      end
      chk("R6 irq_o", {63'd0, irq_o}, {63'd0, m_irq});
      chk("R7 nmi_o", {63'd0, nmi_o}, {63'd0, m_nmi});
      chk("R8 rst_req_o", {63'd0, rst_req_o}, {63'd0, m_rst});
      chk("R9 rdata", rdata, exp_rd);
      if (irq_o) n_irq++;
      if (nmi_o) n_nmi++;
    end
  end

  task automatic wr(input logic [19:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [63:0] d);
    rd_en = 1'b1; addr = a;
    #5 d = rdata;
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] cfg(input int lvl, input int rld, input int cnt);
    return {20'd0, 24'(cnt), 16'(rld), 2'b00, 2'(lvl)};
  endfunction

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [63:0] v;
    wr_en = 0; rd_en = 0; addr = '0; wdata = '0; rst_n = 0;
    wait_clks(3);
    rst_n = 1;
    wait_clks(4);

    // R1 reset state
    rd(A_SETUP, v);
    chk("R1 setup after reset", v, 64'd0);
    chk("R1 outputs after reset", {61'd0, irq_o, nmi_o, rst_req_o}, 64'd0);

    // R10 stray writes
    wr(20'h12345, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(20'h40008, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_SETUP, v);
    chk("R10 stray write ignored", v, 64'd0);

    // R3 field load, junk bits dropped; R9 layout
    wr(A_SETUP, cfg(1, 5, 2) | 64'hFFF0_0000_0000_000C);
    rd(A_SETUP, v);
    chk("R3 setup fields", v, cfg(1, 5, 2));
    rd(A_KICK, v);
    chk("R9 read at restart offset", v, 64'd0);
    rd_en = 1'b0; addr = A_SETUP; #5 v = rdata; addr = '0;
    chk("R9 no strobe", v, 64'd0);

    // R2 prescaler timing
    wait_clks(1023);
    rd(A_SETUP, v);
    chk("R2 before first tick", v[43:20], 64'd2);
    wait_clks(1);
    rd(A_SETUP, v);
    chk("R2 first tick", v[43:20], 64'd1);

    // R6 expiry and reload
    wait_clks(2050);
    chk("R6 one irq", n_irq, 1);
    rd(A_SETUP, v);
    chk("R6 reload value", v[43:20], 64'h500);
    wait_clks(2048);
    rd(A_SETUP, v);
    chk("R2 steady ticks", v[43:20], 64'h4FE);

    // R4 restart
    wr(A_KICK, 64'h0);
    rd(A_SETUP, v);
    chk("R4 restart reload", v[43:20], 64'h500);

    // R5 stop
    wr(A_SETUP, cfg(0, 7, 3));
    wait_clks(3000);
    rd(A_SETUP, v);
    chk("R5 stopped count", v[43:20], 64'd3);
    wr(A_KICK, 64'h1234);
    wait_clks(2100);
    rd(A_SETUP, v);
    chk("R4 restart while stopped", v[43:20], 64'h700);
    chk("R5 no expiry while stopped", n_irq + n_nmi, 1);

    // R7 level 2 escalation
    wr(A_SETUP, cfg(2, 0, 0));
    wait_clks(3 * 1024 + 2);
    chk("R7 level2 irq", n_irq, 2);
    chk("R7 level2 nmi", n_nmi, 2);

    // R8 level 3 with stage cleared by restart
    wr(A_SETUP, cfg(3, 0, 0));
    wait_clks(1026);
    chk("R6 level3 first irq", n_irq, 3);
    wr(A_KICK, 64'h0);
    wait_clks(1026);
    chk("R4 stage cleared", n_irq, 4);
    wait_clks(2048);
    chk("R7 level3 nmi", n_nmi, 3);
    chk("R8 reset request", {63'd0, rst_req_o}, 64'd1);
    wait_clks(3000);
    chk("R8 request held", {63'd0, rst_req_o}, 64'd1);
    chk("R8 no more pulses", n_irq + n_nmi, 7);

    // R1 reset clears request
    @(negedge clk);
    rst_n = 0;
    wait_clks(2);
    rst_n = 1;
    wait_clks(4);
    chk("R1 request cleared", {63'd0, rst_req_o}, 64'd0);
    rd(A_SETUP, v);
    chk("R1 setup cleared", v, 64'd0);

    finish_run();
  end
endmodule